// File: doc/BRIEF.md
# Page-Buffered Self-Timed Write Controller

This block sits between a serial protocol engine and a 1024-byte nonvolatile array that is organised as 64 rows of 128 bits. The engine hands it data bytes, each with a 10-bit byte address. The block gathers these bytes into a 16-byte page buffer. It does not write each byte to the array as it arrives.

When the engine reports a stop condition through the commit strobe, the block launches one self-timed programming cycle. That cycle writes every loaded byte of the page into its array row through a single masked row write. The cycle lasts a programmable number of clock cycles, which stands in for the few milliseconds of real cell programming. The block holds `busy` high for the whole cycle, and the protocol side must treat its own inputs as disabled while `busy` is high.

Control is a three-state machine:
- `ST_IDLE` accepts byte loads and commit strobes. It moves to `ST_LAUNCH` on a commit when at least one byte is loaded, and stays in `ST_IDLE` on any other input.
- `ST_LAUNCH` lasts one cycle, issues the row write and always moves to `ST_HOLD`.
- `ST_HOLD` counts the cycle down. It returns to `ST_IDLE` once the counter reaches zero, and clears the page mask on that same transition.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy` and `arr_we` are 0 and no bytes are marked as loaded.
- R2: A load accepted in idle stores `ld_data` in buffer entry `ld_addr[3:0]`. At commit, the byte of entry i appears on `arr_wdata[8*i+7:8*i]` and bit i of `arr_wmask` is 1. `arr_row` equals `ld_addr[9:4]` of the first load after the mask was last empty.
- R3: The page is fixed by the first load. Later loads use only their low 4 address bits and wrap within that page, so a repeated offset (including one reached from a different upper address) overwrites the earlier byte.
- R4: `arr_wmask` has a 1 exactly at the offsets that were loaded since the last completed cycle.
- R5: A commit while no byte is loaded starts no cycle: `busy` and `arr_we` stay 0.
- R6: A commit with bytes loaded raises `busy` on the next cycle. `arr_we` is 1 in that first busy cycle only.
- R7: `busy` stays high for exactly WRITE_CYCLES consecutive cycles.
- R8: Loads and commits presented while `busy` is high are ignored.
- R9: The mask is cleared on the edge where `busy` falls. The next load then starts a fresh page with its own row.
- R10: A load presented in the same cycle as a commit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Byte load strobe |
| ld_addr | input | 10 | Byte address of the load |
| ld_data | input | 8 | Byte to load |
| commit | input | 1 | Stop-condition strobe that starts the write cycle |
| busy | output | 1 | Write cycle in progress |
| arr_we | output | 1 | Array row write pulse |
| arr_row | output | 6 | Array row being written |
| arr_wdata | output | 128 | Row data, byte i in bits 8i+7..8i |
| arr_wmask | output | 16 | Per-byte write enables for the row |

## Verification
The hardest situation to reach is traffic that arrives while the cycle is running. Its effect shows only later, because the mask is not visible until the next commit. The bench therefore drives random loads and commits on every busy cycle. After `busy` falls it commits with nothing new loaded and expects no cycle to start. Random pages of 1 to 20 loads, some crossing into another page's addresses, exercise the wrap and overwrite paths against a bench-side page model.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_HOLD   = 2'd2
    } pgw_state_e;
endpackage

// File: rtl/pgw_buffer.sv
module pgw_buffer #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         clear,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] row_o,
    output logic [PAGE_BYTES*DATA_W-1:0] data_o,
    output logic [PAGE_BYTES-1:0]        mask_o,
    output logic                         any_o
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int ROW_W = ADDR_W - OFS_W;

    logic [OFS_W-1:0] ofs;
    logic [ROW_W-1:0] row_q;

    assign ofs   = wr_addr[OFS_W-1:0];
    assign any_o = |mask_o;
    assign row_o = row_q;

    // Page row latched by the first load into an empty page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (wr_en && !any_o) begin
            row_q <= wr_addr[ADDR_W-1:OFS_W];
        end
    end

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_entry
        logic [DATA_W-1:0] byte_q;
        logic              hit;

        assign hit = wr_en && (ofs == OFS_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (hit) begin
                byte_q <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_o[i] <= 1'b0;
            end else if (clear) begin
                mask_o[i] <= 1'b0;
            end else if (hit) begin
                mask_o[i] <= 1'b1;
            end
        end

        assign data_o[i*DATA_W +: DATA_W] = byte_q;
    end
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
    parameter int WRITE_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic zero
);
    localparam int CNT_W = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WRITE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pgw_fsm.sv
module pgw_fsm
    import pgw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic any_loaded,
    input  logic tmr_zero,
    output logic load_en,
    output logic start,
    output logic launch,
    output logic finish,
    output logic busy
);
    pgw_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (commit && any_loaded) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_HOLD;
            ST_HOLD:   if (tmr_zero) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en = 1'b0;
        start   = 1'b0;
        launch  = 1'b0;
        finish  = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                load_en = !commit;
                start   = commit && any_loaded;
            end
            ST_LAUNCH: launch = 1'b1;
            ST_HOLD:   finish = tmr_zero;
            default:   busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 50
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_valid,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic [DATA_W-1:0]            ld_data,
    input  logic                         commit,
    output logic                         busy,
    output logic                         arr_we,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] arr_row,
    output logic [PAGE_BYTES*DATA_W-1:0] arr_wdata,
    output logic [PAGE_BYTES-1:0]        arr_wmask
);
    logic load_en, start, launch, finish, any_loaded, tmr_zero;

    pgw_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .any_loaded (any_loaded),
        .tmr_zero   (tmr_zero),
        .load_en    (load_en),
        .start      (start),
        .launch     (launch),
        .finish     (finish),
        .busy       (busy)
    );

    pgw_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .zero  (tmr_zero)
    );

    pgw_buffer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ld_valid && load_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .clear   (finish),
        .row_o   (arr_row),
        .data_o  (arr_wdata),
        .mask_o  (arr_wmask),
        .any_o   (any_loaded)
    );

    assign arr_we = launch;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 50
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  arr_we,
    input logic [PAGE_BYTES-1:0] arr_wmask
);
    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_run <= 0;
        else                 busy_run <= busy_run + 1;
    end

    p_we_only_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
    p_we_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we);
    p_we_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> arr_we);
    p_no_empty_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_wmask != '0));
    p_busy_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == WRITE_CYCLES));
    p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < WRITE_CYCLES));
    p_mask_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (arr_wmask == '0));
    p_frozen_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(arr_wmask)));
endmodule

bind page_write_ctrl pgw_checker #(
    .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .arr_we    (arr_we),
    .arr_wmask (arr_wmask)
);

// File: tb/sim_page_write_ctrl.sv
`timescale 1ns/1ps
module sim_page_write_ctrl;
    localparam int CYC = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_valid = 1'b0;
    logic [9:0]   ld_addr = '0;
    logic [7:0]   ld_data = '0;
    logic         commit = 1'b0;
    logic         busy, arr_we;
    logic [5:0]   arr_row;
    logic [127:0] arr_wdata;
    logic [15:0]  arr_wmask;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  m_buf [16];
    logic [15:0] m_mask = '0;
    logic [5:0]  m_row = '0;

    always #5 clk = ~clk;

    page_write_ctrl #(.WRITE_CYCLES(CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_data(ld_data), .commit(commit), .busy(busy), .arr_we(arr_we),
        .arr_row(arr_row), .arr_wdata(arr_wdata), .arr_wmask(arr_wmask)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_load(input logic [9:0] a, input logic [7:0] d);
        if (m_mask == '0) m_row = a[9:4];
        m_buf[a[3:0]] = d;
        return m_mask | (16'h1 << a[3:0]);
    endfunction

    task automatic load(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        m_mask = model_load(a, d);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // Commit; optional noisy traffic during busy (R8)
    task automatic do_commit(input bit noisy);
        int n;
        bit expect_wr;
        expect_wr = (m_mask != '0);
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        if (!expect_wr) begin
            check(busy == 1'b0, "R5 busy", busy, 0);
            check(arr_we == 1'b0, "R5 we", arr_we, 0);
            @(negedge clk);
            check(busy == 1'b0, "R5 busy later", busy, 0);
            return;
        end
        check(busy == 1'b1, "R6 busy rise", busy, 1);
        check(arr_we == 1'b1, "R6 we", arr_we, 1);
        check(arr_row == m_row, "R2 row", arr_row, m_row);
        check(arr_wmask == m_mask, "R4 mask", arr_wmask, m_mask);
        for (int i = 0; i < 16; i++)
            if (m_mask[i])
                check(arr_wdata[8*i +: 8] == m_buf[i], "R2 R3 data", arr_wdata[8*i +: 8], m_buf[i]);
        n = 1;
        forever begin
            if (noisy) begin
                ld_valid = $urandom_range(0, 1);
                ld_addr  = 10'($urandom);
                ld_data  = 8'($urandom);
                commit   = $urandom_range(0, 1);
            end
            @(negedge clk);
            if (!busy) break;
            n++;
            check(arr_we == 1'b0, "R6 single pulse", arr_we, 0);
        end
        ld_valid = 1'b0;
        commit = 1'b0;
        check(n == CYC, "R7 busy length", n, CYC);
        check(arr_wmask == '0, "R9 mask clear", arr_wmask, 0);
        m_mask = '0;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(arr_we == 1'b0, "R1 we", arr_we, 0);
        check(arr_wmask == '0, "R1 mask", arr_wmask, 0);

        // R5: commit with empty page
        do_commit(1'b0);

        // R10: load together with commit, empty page -> nothing
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = 10'h123; ld_data = 8'h5a; commit = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0; commit = 1'b0;
        check(busy == 1'b0, "R10 no start", busy, 0);
        check(arr_wmask == '0, "R10 load dropped", arr_wmask, 0);

        // R2 R3: single byte, overwrite, wrap from another page
        load(10'h3f5, 8'h11);
        load(10'h3f5, 8'h22);
        load(10'h015, 8'h33);
        load(10'h020, 8'h44);
        do_commit(1'b0);

        // R10 with nonempty page: load on commit cycle excluded
        load(10'h2a1, 8'h77);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = 10'h2a9; ld_data = 8'h99; commit = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0; commit = 1'b0;
        check(arr_wmask == 16'h0002, "R10 mask", arr_wmask, 16'h0002);
        check(arr_row == 6'h2a, "R10 row", arr_row, 6'h2a);
        while (busy) @(negedge clk);
        m_mask = '0;

        // R8: noisy traffic during busy, then empty commit must not start
        load(10'h080, 8'hc3);
        do_commit(1'b1);
        do_commit(1'b0);

        // R9: fresh page after completion picks new row
        load(10'h1c7, 8'hab);
        do_commit(1'b0);

        // Random pages
        for (int r = 0; r < 40; r++) begin
            logic [5:0] pg;
            int nl;
            pg = 6'($urandom);
            nl = $urandom_range(1, 20);
            for (int k = 0; k < nl; k++) begin
                logic [9:0] a;
                a = {($urandom_range(0, 3) == 0) ? 6'($urandom) : pg, 4'($urandom)};
                load(a, 8'($urandom));
            end
            do_commit(r[0]);
            if (r[0]) do_commit(1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule